// File: doc/BRIEF.md
# Scanout position decoder

This block converts one raw reading from a display timing counter into a corrected beam position. The caller supplies either a scanline count (line mode) or a pixel count measured from the start of the frame (pixel mode), together with the programmed timing: total pixels per line, the pixel where horizontal sync begins, total lines per frame, the first line of vertical blanking and the first active line after blanking. The counters lag the nominal position by a fixed amount, so the block first adds a constant offset modulo the counter period. It then splits the result into a line and a pixel within that line, decides whether the position is inside vertical blanking, and reports the line as a signed value.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream. Only one request is in flight at a time. `in_ready` is high only while the block is idle. A result stays on the output registers, unchanged, until the consumer takes it with `out_ready`. Line mode finishes in two cycles. Pixel mode runs a serial divider of one bit per cycle and raises `out_valid` only after the quotient is complete.

The timing inputs must hold steady from acceptance until the result is taken. The following must also hold: htotal is at least 2 and greater than hsync_start, vbl_end is below vbl_start, the line-mode count is below vtotal, and the pixel-mode count is below vtotal × htotal.

Top module: `scanpos_decoder`

## Requirements
- R1: `in_ready` is high exactly when no request is in flight. A request is taken on a cycle with `in_valid` and `in_ready` both high. After that, `in_ready` stays low until the result is taken. While `out_valid` is high and `out_ready` is low, all outputs hold their values. The cycle after a result is taken, `in_ready` is high again. After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: In line mode (`in_pixel_mode` = 0), the corrected line is (count + 1) mod vtotal. A count of vtotal − 1 therefore gives line 0.
- R3: In line mode, `out_hpos` is 0.
- R4: In pixel mode (`in_pixel_mode` = 1), the corrected position is (count + htotal − hsync_start) mod (vtotal × htotal).
- R5: In pixel mode, the line is the corrected position divided by htotal. `out_hpos` is the remainder, which is always below htotal.
- R6: `out_in_vbl` is 1 when the line is at or above vbl_start, or below vbl_end. In pixel mode this is the same test as comparing the position against vbl_start × htotal and vbl_end × htotal.
- R7: A pixel-mode count of htotal × (vbl_start − 1) + hsync_start decodes as line vbl_start with `out_hpos` 0, and as inside blanking. That count minus one decodes as line vbl_start − 1, pixel htotal − 1, outside blanking.
- R8: `out_vpos` is a two's-complement value. Outside blanking it equals the line. Inside blanking, for a line at or above vbl_start it is line − vtotal − vbl_end. For a line below vbl_end it is line − vbl_end. The value is therefore negative exactly when `out_in_vbl` is 1.
- R9: After acceptance, `out_valid` rises within 2 cycles in line mode and within 2·LINE_W + 3 cycles in pixel mode. It never rises before the result is final.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_htotal | input | LINE_W | Pixels per line |
| cfg_hsync_start | input | LINE_W | Pixel where horizontal sync begins |
| cfg_vtotal | input | LINE_W | Lines per frame |
| cfg_vbl_start | input | LINE_W | First line of vertical blanking |
| cfg_vbl_end | input | LINE_W | First active line after the frame wraps |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request can be taken |
| in_pixel_mode | input | 1 | 0: count is a scanline, 1: count is a frame pixel count |
| in_count | input | 2·LINE_W | Raw counter reading |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_vpos | output | LINE_W+2 | Signed line, negative inside blanking |
| out_hpos | output | LINE_W | Pixel within the line (0 in line mode) |
| out_in_vbl | output | 1 | Position is inside vertical blanking |

## Verification
A wrong line offset or a wrong modulo wrap shows up on the very first result near a frame or blanking boundary. Both the line and the blanking flag come out wrong there, as soon as `out_valid` rises. A divider that drops or repeats an iteration corrupts `out_hpos` and `out_vpos` on every pixel-mode result, and it shifts the cycle in which `out_valid` rises. A broken handshake state is visible one cycle later: `in_ready` no longer mirrors the in-flight status, or the held result changes under back-pressure. The bench compares `in_ready` and every held output against a behavioural model on each clock, so any of these faults appears within one transaction.

// File: rtl/scanpos_pkg.sv
package scanpos_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIVIDE,
    ST_CLASS,
    ST_HOLD
  } scan_state_e;
endpackage

// File: rtl/scanpos_corr.sv
// Adds the fixed counter-lag offset and wraps it once into the counter period.
module scanpos_corr #(
  parameter int LINE_W = 12,
  localparam int PIX_W = 2 * LINE_W
) (
  input  logic              pixel_mode,
  input  logic [PIX_W-1:0]  raw,
  input  logic [LINE_W-1:0] htotal,
  input  logic [LINE_W-1:0] hsync_start,
  input  logic [LINE_W-1:0] vtotal,
  output logic [PIX_W-1:0]  pos,
  output logic              over
);
  localparam int PAD_W = PIX_W + 1 - LINE_W;

  logic [PIX_W-1:0]  frame_len;
  logic [LINE_W-1:0] skew;
  logic [PIX_W:0]    sum, limit, wrapped, res;

  assign frame_len = {{LINE_W{1'b0}}, vtotal} * {{LINE_W{1'b0}}, htotal};
  assign skew      = htotal - hsync_start;

  always_comb begin
    if (pixel_mode) begin
      sum   = {1'b0, raw} + {{PAD_W{1'b0}}, skew};
      limit = {1'b0, frame_len};
    end else begin
      sum   = {1'b0, raw} + {{PIX_W{1'b0}}, 1'b1};
      limit = {{PAD_W{1'b0}}, vtotal};
    end
  end

  assign wrapped = sum - limit;
  assign res     = (sum >= limit) ? wrapped : sum;
  assign pos     = res[PIX_W-1:0];
  // Raised when the raw count was already outside one counter period.
  assign over    = (res >= limit);
endmodule

// File: rtl/scanpos_div.sv
// Restoring divider, one quotient bit per cycle.
module scanpos_div #(
  parameter int N_W = 24,
  parameter int D_W = 12,
  parameter int Q_W = 12,
  localparam int CNT_W = $clog2(N_W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] num,
  input  logic [D_W-1:0] den,
  output logic           done,
  output logic [Q_W-1:0] quot,
  output logic [D_W-1:0] rem
);
  logic [N_W-1:0]   num_q;
  logic [D_W-1:0]   rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [D_W:0]     trial, trial_sub;
  logic             fits;

  assign trial     = {rem_q, num_q[N_W-1]};
  assign trial_sub = trial - {1'b0, den};
  assign fits      = ~trial_sub[D_W];
  assign done      = busy_q && (cnt_q == '0);
  assign quot      = num_q[Q_W-1:0];
  assign rem       = rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      num_q  <= num;
      rem_q  <= '0;
      cnt_q  <= CNT_W'(N_W);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        num_q <= {num_q[N_W-2:0], fits};
        rem_q <= fits ? trial_sub[D_W-1:0] : trial[D_W-1:0];
      end
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rem < den)); // R5
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q); // R9
endmodule

// File: rtl/scanpos_vclass.sv
// Blanking test and signed line report.
module scanpos_vclass #(
  parameter int LINE_W = 12,
  localparam int V_W = LINE_W + 2
) (
  input  logic [LINE_W-1:0] line,
  input  logic [LINE_W-1:0] vtotal,
  input  logic [LINE_W-1:0] vbl_start,
  input  logic [LINE_W-1:0] vbl_end,
  output logic              in_vbl,
  output logic [V_W-1:0]    vpos
);
  logic signed [V_W-1:0] l_s, t_s, e_s;
  logic                  above, below;

  assign l_s    = signed'({2'b00, line});
  assign t_s    = signed'({2'b00, vtotal});
  assign e_s    = signed'({2'b00, vbl_end});
  assign above  = (line >= vbl_start);
  assign below  = (line < vbl_end);
  assign in_vbl = above || below;

  always_comb begin
    if (above)      vpos = l_s - t_s - e_s;
    else if (below) vpos = l_s - e_s;
    else            vpos = l_s;
  end
endmodule

// File: rtl/scanpos_decoder.sv
module scanpos_decoder
  import scanpos_pkg::*;
#(
  parameter int LINE_W = 12,
  localparam int PIX_W = 2 * LINE_W,
  localparam int V_W = LINE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] cfg_htotal,
  input  logic [LINE_W-1:0] cfg_hsync_start,
  input  logic [LINE_W-1:0] cfg_vtotal,
  input  logic [LINE_W-1:0] cfg_vbl_start,
  input  logic [LINE_W-1:0] cfg_vbl_end,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_pixel_mode,
  input  logic [PIX_W-1:0]  in_count,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [V_W-1:0]    out_vpos,
  output logic [LINE_W-1:0] out_hpos,
  output logic              out_in_vbl
);
  scan_state_e       state_q;
  logic              pix_q;
  logic [LINE_W-1:0] line_q, hpos_q;
  logic [PIX_W-1:0]  corr_pos;
  logic              corr_over;
  logic              accept, div_start, div_done;
  logic [LINE_W-1:0] div_quot, div_rem;
  logic              cls_vbl;
  logic [V_W-1:0]    cls_vpos;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign accept    = in_valid && in_ready;
  assign div_start = accept && in_pixel_mode;

  scanpos_corr #(.LINE_W(LINE_W)) u_corr (
    .pixel_mode (in_pixel_mode),
    .raw        (in_count),
    .htotal     (cfg_htotal),
    .hsync_start(cfg_hsync_start),
    .vtotal     (cfg_vtotal),
    .pos        (corr_pos),
    .over       (corr_over)
  );

  scanpos_div #(.N_W(PIX_W), .D_W(LINE_W), .Q_W(LINE_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .start(div_start),
    .num  (corr_pos),
    .den  (cfg_htotal),
    .done (div_done),
    .quot (div_quot),
    .rem  (div_rem)
  );

  scanpos_vclass #(.LINE_W(LINE_W)) u_vclass (
    .line     (line_q),
    .vtotal   (cfg_vtotal),
    .vbl_start(cfg_vbl_start),
    .vbl_end  (cfg_vbl_end),
    .in_vbl   (cls_vbl),
    .vpos     (cls_vpos)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pix_q      <= 1'b0;
      line_q     <= '0;
      hpos_q     <= '0;
      out_vpos   <= '0;
      out_hpos   <= '0;
      out_in_vbl <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          pix_q <= in_pixel_mode;
          if (in_pixel_mode) begin
            state_q <= ST_DIVIDE;
          end else begin
            line_q  <= corr_pos[LINE_W-1:0];
            hpos_q  <= '0;
            state_q <= ST_CLASS;
          end
        end
        ST_DIVIDE: if (div_done) begin
          line_q  <= div_quot;
          hpos_q  <= div_rem;
          state_q <= ST_CLASS;
        end
        ST_CLASS: begin
          out_vpos   <= cls_vpos;
          out_hpos   <= hpos_q;
          out_in_vbl <= cls_vbl;
          state_q    <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vpos) && $stable(out_hpos)
      && $stable(out_in_vbl)); // R1
  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !corr_over); // R2
  AST_LINE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLASS) |-> (line_q < cfg_vtotal)); // R4
  AST_LINE_HPOS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !pix_q |-> (out_hpos == '0)); // R3
  AST_VPOS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_in_vbl == out_vpos[V_W-1])); // R8
endmodule

// File: tb/scanpos_decoder_tb.sv
module scanpos_decoder_tb;
  localparam int LW = 12;
  localparam int PW = 2 * LW;
  localparam int VW = LW + 2;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_pixel_mode = 1'b0;
  logic [PW-1:0] in_count = '0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_in_vbl;
  logic [VW-1:0] out_vpos;
  logic [LW-1:0] out_hpos;

  int ht = 20, hs = 14, vt = 12, vs = 9, ve = 1;
  int compared = 0, mismatched = 0, cycles = 0;
  bit busy_m = 0, waiting = 0, bp_en = 0, finished = 0;
  int lat = 0, lat_bound = 0;
  int unsigned lcg = 32'h1234_5678, lcg2 = 32'h0bad_f00d;
  int q_v[$], q_h[$];
  bit q_b[$], q_p[$];

  always #2 clk = ~clk;  // 250 MHz

  scanpos_decoder #(.LINE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_htotal(LW'(ht)), .cfg_hsync_start(LW'(hs)), .cfg_vtotal(LW'(vt)),
    .cfg_vbl_start(LW'(vs)), .cfg_vbl_end(LW'(ve)),
    .in_valid(in_valid), .in_ready(in_ready), .in_pixel_mode(in_pixel_mode),
    .in_count(in_count), .out_valid(out_valid), .out_ready(out_ready),
    .out_vpos(out_vpos), .out_hpos(out_hpos), .out_in_vbl(out_in_vbl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic predict(input bit pix, input int raw, output int v, output int h, output bit b);
    int l, p;
    if (pix) begin
      p = (raw + ht - hs) % (vt * ht);
      l = p / ht;
      h = p % ht;
    end else begin
      l = (raw + 1) % vt;
      h = 0;
    end
    b = (l >= vs) || (l < ve);
    if (!b) v = l;
    else if (l >= vs) v = l - vt - ve;
    else v = l - ve;
  endtask

  // Monitor and reference model, evaluated away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      int ev, eh;
      bit eb;
      chk("R1 in_ready", int'(in_ready), int'(!busy_m));
      if (waiting) begin
        if (out_valid) begin
          compared++;
          if (lat > lat_bound) begin
            mismatched++;
            $display("FAIL R9 latency: actual %0d expected <= %0d", lat, lat_bound);
          end
          waiting = 0;
        end else lat++;
      end
      if (out_valid) begin
        if (q_v.size() == 0) chk("R1 spurious out_valid", 1, 0);
        else begin
          chk("R8 out_vpos", int'($signed(out_vpos)), q_v[0]);
          chk(q_p[0] ? "R5 out_hpos" : "R3 out_hpos", int'(out_hpos), q_h[0]);
          chk("R6 out_in_vbl", int'(out_in_vbl), int'(q_b[0]));
        end
      end
      if (out_valid && out_ready) begin
        if (q_v.size() != 0) begin
          void'(q_v.pop_front()); void'(q_h.pop_front());
          void'(q_b.pop_front()); void'(q_p.pop_front());
        end
        busy_m = 0;
      end
      if (in_valid && in_ready) begin
        predict(in_pixel_mode, int'(in_count), ev, eh, eb);
        q_v.push_back(ev); q_h.push_back(eh); q_b.push_back(eb); q_p.push_back(in_pixel_mode);
        busy_m = 1;
        waiting = 1;
        lat = 0;
        lat_bound = in_pixel_mode ? PW + 3 : 2;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (bp_en) begin
      lcg2 = lcg2 * 32'd1664525 + 32'd1013904223;
      out_ready = lcg2[21] & lcg2[17];
    end else out_ready = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic send(input bit pix, input int raw);
    bit acc = 0;
    in_pixel_mode = pix;
    in_count = PW'(raw);
    in_valid = 1'b1;
    while (!acc) begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (busy_m) @(posedge clk);
    #1;
  endtask

  function automatic int rnd(input int range);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'(lcg[30:8]) % range;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset out_valid", int'(out_valid), 0);
    chk("R1 reset in_ready", int'(in_ready), 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R2 R3 R6 R8: line mode around both frame and blanking boundaries
    send(0, 0);  drain();
    send(0, 7);  drain();
    send(0, 8);  drain();   // line 9 = vbl_start
    send(0, 10); drain();
    send(0, 11); drain();   // wraps to line 0, below vbl_end
    send(0, 5);  drain();

    // R4 R5 R7: pixel mode, including the blanking-start event
    send(1, 20 * 8 + 14); drain();  // R7: line 9, pixel 0, in blanking
    send(1, 20 * 8 + 13); drain();  // R7: line 8, pixel 19, active
    send(1, 239); drain();          // R4: wraps past frame end
    send(1, 0);   drain();
    send(1, 40);  drain();
    send(1, 225); drain();

    // R1: back-pressure with back-to-back requests, mixed modes
    bp_en = 1;
    for (int i = 0; i < 40; i++) begin
      if (rnd(2) == 1) send(1, rnd(vt * ht));
      else send(0, rnd(vt));
    end
    drain();
    bp_en = 0;
    repeat (3) @(posedge clk);
    #1;

    // Second timing set, no top blanking lines
    ht = 800; hs = 656; vt = 525; vs = 480; ve = 0;
    @(posedge clk); #1;
    send(1, 800 * 479 + 656); drain();  // R7
    send(0, 524); drain();              // R2: wraps to 0
    for (int i = 0; i < 60; i++) begin
      if (i % 3 == 0) send(0, rnd(vt));
      else send(1, rnd(vt * ht));
      if (i % 5 == 0) drain();
    end
    drain();
    bp_en = 1;
    ht = 100; hs = 90; vt = 30; vs = 25; ve = 3;
    @(posedge clk); #1;
    for (int i = 0; i < 30; i++) send(1, rnd(vt * ht));
    drain();
    repeat (4) @(posedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule